// File: doc/BRIEF.md
# Banked Shared Configuration Register File

This block is a byte-wide register file on a simple synchronous bus (address, write data, write enable, combinational read data). Most addresses hold one register each. Twelve scattered addresses are held twice: one copy configures a primary timing path and the other configures a secondary timing path. A single select bit, held in a global configuration register at address 0x07, decides which of the two copies a bus access reaches.

Both copies are exported all the time as two parallel output vectors, so each path always sees its own settings whatever the select bit says. Software sets the select bit once, programs or inspects one path's copy through the shared addresses, then flips the bit to reach the other copy.

Top module: `shared_cfg_regfile`

## Requirements
- R1: After reset the select bit is 0, every address reads 0x00, and both exported vectors are all zero.
- R2: Address 0x07 keeps only bit 4 (the select bit). Writes set or clear that bit; bits 7..5 and 3..0 always read 0 and ignore writes.
- R3: With select 0, a write to a banked address updates only the primary copy; the secondary copy is left unchanged.
- R4: With select 1, a write to a banked address updates only the secondary copy; the primary copy is left unchanged.
- R5: A read of a banked address returns the primary copy when select is 0 and the secondary copy when select is 1, using the select value in force in that cycle.
- R6: A write to 0x07 changes the select bit at the clock edge that ends the write, so the very next bus cycle already uses the new value.
- R7: The banked addresses are exactly 0x27, 0x28, 0x2A, 0x4E, 0x4F, 0x5A, 0x5B, 0x62, 0x63, 0x64, 0x68, 0x69. Any other address (except 0x07) is one plain register that reads the same under either select value, and writing it leaves both exported vectors unchanged.
- R8: Banked slot k occupies bits [8k+7:8k] of each exported vector, with slots numbered 0..11 in ascending address order (0x27 is slot 0, 0x69 is slot 11).
- R9: A write changes only the register it addresses; neighbouring addresses keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 7 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pri_cfg | output | 96 | Primary-path copies of the twelve banked registers |
| sec_cfg | output | 96 | Secondary-path copies of the twelve banked registers |

## Verification
The same banked address is written once under each select value with different data, then read back after toggling the select, which separates a correct steering from one that ignores the bit or writes both copies. A read issued in the cycle right after a select write tells an immediate select update apart from one delayed by a cycle. Plain addresses next to and between banked ones are written under one select value and read under the other, separating true single registers from ones wrongly banked, and the exported vectors are compared whole to catch writes landing in the wrong slot or copy.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int NUM_ADDR   = 1 << ADDR_W;
  localparam int NUM_BANKED = 12;
  localparam int SLOT_W     = $clog2(NUM_BANKED);
  localparam int BANK_W     = NUM_BANKED * DATA_W;
  localparam int SEL_BIT    = 4;
  localparam logic [ADDR_W-1:0] SEL_ADDR = 7'h07;

  // Banked addresses in ascending order; position in the list is the slot.
  localparam logic [ADDR_W-1:0] BANKED_ADDR [NUM_BANKED] = '{
    7'h27, 7'h28, 7'h2A, 7'h4E, 7'h4F, 7'h5A,
    7'h5B, 7'h62, 7'h63, 7'h64, 7'h68, 7'h69
  };

  function automatic logic is_banked(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_BANKED; i++)
      if (BANKED_ADDR[i] == a) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    logic [SLOT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_BANKED; i++)
      if (BANKED_ADDR[i] == a) s = SLOT_W'(i);
    return s;
  endfunction

  // Read-back image of the select register: only the select bit is kept.
  function automatic logic [DATA_W-1:0] sel_image(input logic sel);
    logic [DATA_W-1:0] v;
    v = '0;
    v[SEL_BIT] = sel;
    return v;
  endfunction
endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
  import bcr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              sel,
  output logic              hit_sel,
  output logic              hit_banked,
  output logic [SLOT_W-1:0] slot,
  output logic              wr_sel,
  output logic              wr_pri,
  output logic              wr_sec,
  output logic              wr_plain
);
  always_comb begin
    hit_sel    = (addr == SEL_ADDR);
    hit_banked = is_banked(addr);
    slot       = slot_of(addr);
    wr_sel     = we && hit_sel;
    wr_pri     = we && hit_banked && !sel;
    wr_sec     = we && hit_banked && sel;
    wr_plain   = we && !hit_banked && !hit_sel;
  end
endmodule

// File: rtl/bcr_bank.sv
module bcr_bank
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] cfg
);
  for (genvar k = 0; k < NUM_BANKED; k++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              q <= '0;
      else if (wr_en && slot == SLOT_W'(k))    q <= wdata;
    end
    assign cfg[k*DATA_W +: DATA_W] = q;
  end

  // Without a write strobe the copy holds every bit.
  assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/bcr_plain.sv
module bcr_plain
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_ADDR*DATA_W-1:0] flat;

  for (genvar a = 0; a < NUM_ADDR; a++) begin : g_addr
    if (is_banked(ADDR_W'(a)) || ADDR_W'(a) == SEL_ADDR) begin : g_none
      assign flat[a*DATA_W +: DATA_W] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            q <= '0;
        else if (wr_en && addr == ADDR_W'(a))  q <= wdata;
      end
      assign flat[a*DATA_W +: DATA_W] = q;
    end
  end

  assign rdata = flat[addr*DATA_W +: DATA_W];
endmodule

// File: rtl/shared_cfg_regfile.sv
module shared_cfg_regfile
  import bcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BANK_W-1:0] pri_cfg,
  output logic [BANK_W-1:0] sec_cfg
);
  logic              sel_q;
  logic              hit_sel, hit_banked;
  logic [SLOT_W-1:0] slot;
  logic              wr_sel, wr_pri, wr_sec, wr_plain;
  logic [DATA_W-1:0] plain_rdata;
  logic [DATA_W-1:0] pri_rdata, sec_rdata;

  bcr_decode u_dec (
    .addr(bus_addr), .we(bus_we), .sel(sel_q),
    .hit_sel(hit_sel), .hit_banked(hit_banked), .slot(slot),
    .wr_sel(wr_sel), .wr_pri(wr_pri), .wr_sec(wr_sec), .wr_plain(wr_plain)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= 1'b0;
    else if (wr_sel) sel_q <= bus_wdata[SEL_BIT];
  end

  bcr_bank u_pri (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_pri), .slot(slot),
    .wdata(bus_wdata), .cfg(pri_cfg)
  );

  bcr_bank u_sec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sec), .slot(slot),
    .wdata(bus_wdata), .cfg(sec_cfg)
  );

  bcr_plain u_plain (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_plain), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(plain_rdata)
  );

  assign pri_rdata = pri_cfg[slot*DATA_W +: DATA_W];
  assign sec_rdata = sec_cfg[slot*DATA_W +: DATA_W];

  always_comb begin
    if (hit_sel)         bus_rdata = sel_image(sel_q);
    else if (hit_banked) bus_rdata = sel_q ? sec_rdata : pri_rdata;
    else                 bus_rdata = plain_rdata;
  end

  // Reserved bits of the select register never read as 1.
  assert_sel_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SEL_ADDR) |-> ((bus_rdata & ~(DATA_W'(1) << SEL_BIT)) == '0));

  // With select 0 the secondary copy is never disturbed.
  assert_sec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |=> $stable(sec_cfg));

  // With select 1 the primary copy is never disturbed.
  assert_pri_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> $stable(pri_cfg));

  // Select write is visible in the following cycle.
  assert_sel_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == SEL_ADDR) |=> (sel_q == $past(bus_wdata[SEL_BIT])));

  // Non-banked writes leave both exported vectors alone.
  assert_plain_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !is_banked(bus_addr)) |=> ($stable(pri_cfg) && $stable(sec_cfg)));
endmodule

// File: tb/shared_cfg_regfile_tb.sv
module shared_cfg_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_rdata;
  logic [95:0] pri_cfg, sec_cfg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shared_cfg_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pri_cfg(pri_cfg), .sec_cfg(sec_cfg)
  );

  typedef struct packed {
    logic       we;
    logic [6:0] addr;
    logic [7:0] wd;
    logic [7:0] exp;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 24;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 7'h07, 8'h00, 8'h00, 4'd1},  // R1 select reads 0
    '{1'b0, 7'h27, 8'h00, 8'h00, 4'd1},  // R1 banked reads 0
    '{1'b1, 7'h27, 8'hA5, 8'h00, 4'd3},  // R3 write primary
    '{1'b0, 7'h27, 8'h00, 8'hA5, 4'd3},
    '{1'b1, 7'h07, 8'hFF, 8'h00, 4'd2},  // R2 set select, all bits written
    '{1'b0, 7'h27, 8'h00, 8'h00, 4'd6},  // R6 next cycle sees secondary
    '{1'b0, 7'h07, 8'h00, 8'h10, 4'd2},  // R2 only bit 4 kept
    '{1'b1, 7'h27, 8'h3C, 8'h00, 4'd4},  // R4 write secondary
    '{1'b0, 7'h27, 8'h00, 8'h3C, 4'd4},
    '{1'b1, 7'h69, 8'h77, 8'h00, 4'd4},
    '{1'b1, 7'h29, 8'h5A, 8'h00, 4'd7},  // R7 plain write under select 1
    '{1'b1, 7'h07, 8'hEF, 8'h00, 4'd2},  // R2 bit4 clear, others set
    '{1'b0, 7'h07, 8'h00, 8'h00, 4'd2},
    '{1'b0, 7'h27, 8'h00, 8'hA5, 4'd5},  // R5 primary visible again
    '{1'b0, 7'h69, 8'h00, 8'h00, 4'd5},
    '{1'b0, 7'h29, 8'h00, 8'h5A, 4'd7},  // R7 same under select 0
    '{1'b1, 7'h65, 8'hC3, 8'h00, 4'd7},
    '{1'b1, 7'h07, 8'h10, 8'h00, 4'd6},
    '{1'b0, 7'h65, 8'h00, 8'hC3, 4'd7},  // R7 0x65 is not banked
    '{1'b0, 7'h69, 8'h00, 8'h77, 4'd5},
    '{1'b0, 7'h28, 8'h00, 8'h00, 4'd9},  // R9 neighbours untouched
    '{1'b0, 7'h2A, 8'h00, 8'h00, 4'd9},
    '{1'b0, 7'h26, 8'h00, 8'h00, 4'd9},
    '{1'b0, 7'h6A, 8'h00, 8'h00, 4'd9}
  };

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_step(input logic we, input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: exported vectors clear out of reset
    chk("R1 pri_cfg", pri_cfg, '0);
    chk("R1 sec_cfg", sec_cfg, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NSTEP; i++) begin
      bus_step(STEPS[i].we, STEPS[i].addr, STEPS[i].wd);
      if (!STEPS[i].we)
        chk($sformatf("R%0d step %0d addr %h", STEPS[i].req, i, STEPS[i].addr),
            96'(bus_rdata), 96'(STEPS[i].exp));
    end
    bus_step(1'b0, 7'h00, 8'h00);

    // R8: slot 0 (0x27) low byte, slot 11 (0x69) high byte
    chk("R8 pri_cfg", pri_cfg, 96'h0000_0000_0000_0000_0000_00A5);
    chk("R8 sec_cfg", sec_cfg, 96'h7700_0000_0000_0000_0000_003C);

    // R3: write 0x64 (slot 9) under select 0, secondary unchanged
    bus_step(1'b1, 7'h07, 8'h00);
    bus_step(1'b1, 7'h64, 8'h9E);
    bus_step(1'b0, 7'h64, 8'h00);
    chk("R3 read 0x64", 96'(bus_rdata), 96'h9E);
    chk("R3 R8 pri slot9", pri_cfg, 96'h0000_9E00_0000_0000_0000_00A5);
    chk("R3 sec unchanged", sec_cfg, 96'h7700_0000_0000_0000_0000_003C);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 reset pri", pri_cfg, '0);
    chk("R1 reset sec", sec_cfg, '0);
    bus_addr = 7'h29; #1;
    chk("R1 reset plain", 96'(bus_rdata), 96'h0);
    bus_addr = 7'h07; #1;
    chk("R1 reset select", 96'(bus_rdata), 96'h0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule